// File: doc/BRIEF.md
# BCD Real-Time Clock with Frozen Host View

This block keeps calendar time in packed BCD, 24-hour form, and shows it to a host through a byte-wide register window of eight addresses. Two layers of state exist: live counters, which advance once per second after a parameterised number of `tick_en` pulses, and holding registers, which are all the host can read or write. When neither control bit is set, the holding registers copy the live counters on every clock. This means a read never sees a field that is changing.

The century register also carries two control bits. The freeze bit stops the holding registers from updating, so the host can read a coherent snapshot while the counters keep running. The load bit also stops updates and opens the time fields for writing. Clearing the load bit moves the whole holding set, plus the century value written in that same access, into the live counters at one clock edge. The same clearing restarts the sub-second prescaler. Bus strobes are active low and sampled on `clk`.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset, the window at addresses 0..7 reads 0x00 (seconds), 0x00 (minutes), 0x00 (hours), 0x01 (weekday), 0x01 (date), 0x01 (month), 0x00 (year) and 0x20 (century). The control bits (address 7 bit 7 = load, bit 6 = freeze) read back clear.
- R2: Every TICKS_PER_SEC-th `tick_en` pulse advances the live seconds by one. When both control bits are clear, the new value can be read at address 0 from the second clock after that pulse.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00. On the hours wrap the weekday steps from 7 to 1 (otherwise it increments) and the date advances.
- R4: The date wraps to 0x01 after the last day of the month: 31 in months 1,3,5,7,8,10,12; 30 in months 4,6,9,11; 29 in February of years divisible by four (including 00); 28 otherwise. The wrap carries into the month, which wraps from 0x12 to 0x01.
- R5: The year wraps from 0x99 to 0x00 and carries into the century (6-bit BCD field, 0x00..0x39).
- R6: While the freeze bit is set, reads return the values captured before it was set, and the live counters keep advancing. After the bit is cleared, reads show the advanced time.
- R7: While the load bit is set, writes to addresses 0..6 land in the holding registers and read back as written. With the load bit clear, writes to addresses 0..6 have no effect.
- R8: A write to address 7 with bit 7 = 0 while the load bit is set copies holding addresses 0..6 and wdata[5:0] into the live counters in one step. It also restarts the prescaler, so the next second advances only after TICKS_PER_SEC further pulses.
- R9: A write is committed once, on the clock where `ce_n` and `we_n` are first both low. With either one high, nothing is written. The address must stay stable while both are low.
- R10: `rdata` carries the addressed register only while `ce_n` and `oe_n` are low and `we_n` is high. At all other times it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler input pulse, one clock wide |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not selected |

## Verification
A wrong carry or month length in the live counters reaches the ports only one clock after the faulty edge, through the holding copy. The bench therefore steps seconds at the exact rollover points and reads back all eight fields. A holding register that leaks counter values while frozen shows up as a changed seconds read within one second of tick pulses. A load that misses a field or keeps the old prescaler phase shows up in the first full read after loading, or as a seconds step one pulse too early.

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_SEC - 1);

  logic [7:0] cnt  [8];
  logic [7:0] hold [8];
  logic [7:0] nxt  [8];
  logic [PW-1:0] psc;
  logic ctl_r, ctl_w, wr_q;
  logic wr_now, wr_stb, load, sec_pulse, rd_en;
  logic [7:0] mlast;

  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] max,
                                          input logic [7:0] min);
    if (v == max)          return min;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                   return v + 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  assign wr_now    = ~ce_n & ~we_n;
  assign wr_stb    = wr_now & ~wr_q;
  assign load      = wr_stb & (addr == 3'd7) & ctl_w & ~wdata[7];
  assign sec_pulse = tick_en & (psc == PLAST) & ~load;
  assign rd_en     = ~ce_n & ~oe_n & we_n;
  assign mlast     = month_len(cnt[5], cnt[6]);
  assign rdata     = !rd_en ? 8'h00 :
                     (addr == 3'd7) ? {ctl_w, ctl_r, hold[7][5:0]} : hold[addr];

  always_comb begin
    for (int i = 0; i < 8; i++) nxt[i] = cnt[i];
    if (sec_pulse) begin
      nxt[0] = bcd_next(cnt[0], 8'h59, 8'h00);
      if (cnt[0] == 8'h59) begin
        nxt[1] = bcd_next(cnt[1], 8'h59, 8'h00);
        if (cnt[1] == 8'h59) begin
          nxt[2] = bcd_next(cnt[2], 8'h23, 8'h00);
          if (cnt[2] == 8'h23) begin
            nxt[3] = bcd_next(cnt[3], 8'h07, 8'h01);
            nxt[4] = bcd_next(cnt[4], mlast, 8'h01);
            if (cnt[4] == mlast) begin
              nxt[5] = bcd_next(cnt[5], 8'h12, 8'h01);
              if (cnt[5] == 8'h12) begin
                nxt[6] = bcd_next(cnt[6], 8'h99, 8'h00);
                if (cnt[6] == 8'h99) nxt[7] = bcd_next(cnt[7], 8'h39, 8'h00);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        cnt[i]  <= (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
        hold[i] <= (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
      end
      cnt[7]  <= 8'h20;
      hold[7] <= 8'h20;
      psc     <= '0;
      ctl_r   <= 1'b0;
      ctl_w   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= wr_now;

      if (load)
        psc <= '0;
      else if (tick_en)
        psc <= (psc == PLAST) ? '0 : psc + PW'(1);

      if (load) begin
        for (int i = 0; i < 7; i++) cnt[i] <= hold[i];
        cnt[7] <= {2'b00, wdata[5:0]};
      end else begin
        for (int i = 0; i < 8; i++) cnt[i] <= nxt[i];
      end

      if (!ctl_r && !ctl_w)
        for (int i = 0; i < 8; i++) hold[i] <= cnt[i];
      if (wr_stb && ctl_w)
        hold[addr] <= (addr == 3'd7) ? {2'b00, wdata[5:0]} : wdata;

      if (wr_stb && addr == 3'd7) begin
        ctl_w <= wdata[7];
        ctl_r <= wdata[6];
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_regs_sva.sv
module rtc_bcd_regs_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic       ctl_r,
  input logic       ctl_w,
  input logic [7:0] c_sec,
  input logic [7:0] c_hr,
  input logic [7:0] c_date,
  input logic [7:0] h_sec
);
  a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> rdata == 8'h00);

  a_r3_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    c_sec[3:0] <= 4'd9 && c_sec <= 8'h59);

  a_r3_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    c_hr[3:0] <= 4'd9 && c_hr <= 8'h23);

  a_r4_date_range: assert property (@(posedge clk) disable iff (!rst_n)
    c_date != 8'h00 && c_date <= 8'h31);

  a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_r && !ctl_w) |=> $stable(h_sec));

  a_r8_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_w) |-> c_sec == $past(h_sec));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> (ce_n || we_n || $stable(addr)));
endmodule

bind rtc_bcd_regs rtc_bcd_regs_sva u_sva (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .rdata(rdata), .ctl_r(ctl_r), .ctl_w(ctl_w),
  .c_sec(cnt[0]), .c_hr(cnt[2]), .c_date(cnt[4]), .h_sec(hold[0])
);

// File: tb/tb_rtc_bcd_regs.sv
`timescale 1ns/1ps
module tb_rtc_bcd_regs;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int tests = 0, fails = 0;
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cen;

  always #2.5 clk = ~clk;

  rtc_bcd_regs #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hr++; end
    if (m_hr == 24) begin
      m_hr = 0;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      m_date++;
      if (m_date > mlen(m_mon, m_yr)) begin m_date = 1; m_mon++; end
      if (m_mon == 13) begin m_mon = 1; m_yr++; end
      if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen + 1) % 40; end
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic seconds(input int n);
    for (int i = 0; i < n; i++) begin
      pulses(TPS);
      model_step();
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    bus_read(3'd0, d); check(req, d, bcd(m_sec));
    bus_read(3'd1, d); check(req, d, bcd(m_min));
    bus_read(3'd2, d); check(req, d, bcd(m_hr));
    bus_read(3'd3, d); check(req, d, bcd(m_dow));
    bus_read(3'd4, d); check(req, d, bcd(m_date));
    bus_read(3'd5, d); check(req, d, bcd(m_mon));
    bus_read(3'd6, d); check(req, d, bcd(m_yr));
    bus_read(3'd7, d); check(req, d, bcd(m_cen));
  endtask

  task automatic load_time(input int s, input int mi, input int h, input int dw,
                           input int dt, input int mo, input int y, input int c);
    logic [7:0] d;
    bus_write(3'd7, 8'h80);
    bus_write(3'd0, bcd(s));  bus_write(3'd1, bcd(mi)); bus_write(3'd2, bcd(h));
    bus_write(3'd3, bcd(dw)); bus_write(3'd4, bcd(dt)); bus_write(3'd5, bcd(mo));
    bus_write(3'd6, bcd(y));
    bus_read(3'd0, d); check("R7 holding write readback", d, bcd(s));
    bus_write(3'd7, bcd(c));
    m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y; m_cen = c;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'd1744));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_cen = 20;
    check_all("R1 reset value");

    seconds(1);
    check_all("R2 one second");
    pulses(TPS - 1);
    bus_read(3'd0, d); check("R2 no step early", d, bcd(m_sec));
    pulses(1); model_step();
    bus_read(3'd0, d); check("R2 step on last pulse", d, bcd(m_sec));

    load_time(59, 59, 23, 7, 31, 12, 99, 20);
    check_all("R8 loaded time");
    seconds(1);
    check_all("R3 R5 year and century carry");

    load_time(59, 59, 23, 3, 28, 2, 24, 20);
    seconds(1);
    check_all("R4 leap Feb 29");
    load_time(59, 59, 23, 4, 29, 2, 24, 20);
    seconds(1);
    check_all("R4 leap Mar 1");
    load_time(59, 59, 23, 2, 28, 2, 23, 20);
    seconds(1);
    check_all("R4 common year Mar 1");
    load_time(59, 59, 23, 5, 30, 4, 0, 21);
    seconds(1);
    check_all("R4 thirty day month");

    load_time(10, 0, 12, 1, 15, 6, 50, 20);
    bus_write(3'd7, 8'h40);
    bus_read(3'd0, d);
    seconds(1);
    bus_read(3'd0, d2); check("R6 frozen across tick", d2, d);
    bus_read(3'd7, d2); check("R6 freeze bit readback", d2, 8'h40 | bcd(m_cen));
    seconds(1);
    bus_write(3'd7, 8'h00);
    repeat (2) @(negedge clk);
    check_all("R6 thaw shows advanced time");

    bus_write(3'd0, 8'h33);
    repeat (2) @(negedge clk);
    check_all("R7 write ignored when load clear");

    pulses(2);
    load_time(0, 30, 8, 2, 10, 10, 30, 20);
    pulses(TPS - 1);
    bus_read(3'd0, d); check("R8 prescaler restarted", d, 8'h00);
    pulses(1); model_step();
    bus_read(3'd0, d); check("R8 first second after load", d, 8'h01);

    @(negedge clk); ce_n = 1'b1; we_n = 1'b0; addr = 3'd7; wdata = 8'h80;
    @(negedge clk); we_n = 1'b1;
    bus_read(3'd7, d); check("R9 no write without ce_n", d, bcd(m_cen));
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 3'd7; wdata = 8'h40;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    bus_read(3'd7, d); check("R9 held strobe single write", d, 8'h40 | bcd(m_cen));
    bus_write(3'd7, 8'h00);

    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 3'd3;
    #1 check("R10 oe_n high", rdata, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    #1 check("R10 ce_n high", rdata, 8'h00);
    oe_n = 1'b1;

    for (int k = 0; k < 20; k++) begin
      int s, mi, h, mo, y, dt;
      bit edge_case;
      edge_case = $urandom_range(1, 0) == 1;
      s  = edge_case ? 59 : $urandom_range(59, 0);
      mi = edge_case ? 59 : $urandom_range(59, 0);
      h  = edge_case ? 23 : $urandom_range(23, 0);
      mo = $urandom_range(12, 1);
      y  = $urandom_range(99, 0);
      dt = edge_case ? mlen(mo, y) : $urandom_range(mlen(mo, y), 1);
      load_time(s, mi, h, $urandom_range(7, 1), dt, mo, y, $urandom_range(39, 0));
      seconds($urandom_range(3, 1));
      check_all("R3 R4 random time");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule